// File: doc/BRIEF.md
# Spill-Synchronized Readout Arbiter

This block sits on a detector readout board and collects events from a set of channel managers into a pair of alternating readout memories. Each channel manager posts a priority for its oldest waiting event and a flag for buffers that still hold data from the previous spill. The arbiter grants one channel at a time. It copies a fixed-length event from that channel's data lane, one word per cycle, into the memory currently assigned for writing.

A free-running spill timer counts clocks inside each spill and wraps at the spill length. Each wrap requests a swap of the two memories. The swap is held back until three conditions hold together: no channel reports a critical buffer, no event transfer is in progress, and the host has finished reading the previous memory. Event transfers keep running while the swap waits, so no trigger is lost.

When the swap takes place, the arbiter raises a ready flag toward the host. It also reports which memory the host should read and how many words were written into it. The host clears the ready flag with an acknowledge pulse once it has finished reading.

Top module: `rdo_arbiter`

## Requirements
- R1: At most one grant bit is high at any time. A transfer holds the same one-hot grant for exactly EVT_WORDS consecutive cycles. In each of those cycles the granted channel's data lane (lane i = chanData bits i*DW and up) is written to the write memory at consecutive addresses, unless the memory is full.
- R2: A new transfer is granted to the channel with the largest priority value. A priority of 0 means that channel has no request.
- R3: When several channels share the largest non-zero priority, the lowest-numbered one among them is granted.
- R4: The spill timer equals the number of clock edges since reset, modulo SPILL_CLKS. Every wrap from SPILL_CLKS-1 to 0 posts a swap request.
- R5: A posted swap waits while any chanCrit bit is high or a transfer is running. New transfers are still granted and written while the swap is waiting.
- R6: A swap never happens while rdReady is high. A hostAck pulse clears rdReady on the next edge.
- R7: A swap inverts memWrBank and sets rdReady. It sets rdBank to the memory just filled and rdCount to the number of words written into it. The write address restarts at 0.
- R8: Once DEPTH words have been written since the last swap, memWrEn stays low and memFull stays high until the next swap.
- R9: After reset there is no grant and no write, rdReady is 0, memWrBank is 0, memFull is 0 and spillTime is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanPrio | input | NCH*PW | Per-channel priority, 0 means no request |
| chanCrit | input | NCH | Per-channel flag for a buffer that still holds old-spill data |
| chanData | input | NCH*DW | Per-channel event data lanes |
| hostAck | input | 1 | Host finished reading the handed-over memory |
| grant | output | NCH | One-hot transfer grant |
| memWrEn | output | 1 | Write strobe to the write memory |
| memWrBank | output | 1 | Index of the memory being written |
| memWrAddr | output | $clog2(DEPTH) | Write address |
| memWrData | output | DW | Write data |
| spillTime | output | $clog2(SPILL_CLKS) | Clock count inside the current spill |
| rdReady | output | 1 | Handed-over memory is ready for the host |
| rdBank | output | 1 | Index of the memory the host reads |
| rdCount | output | $clog2(DEPTH)+1 | Words written into the handed-over memory |
| memFull | output | 1 | Write memory has filled since the last swap |

## Verification
Arbitration is swept over every combination of four 2-bit priorities. This separates strict-maximum selection from ties, where the lowest index must win, and from the all-zero case, where no grant must appear. Every transfer in the sweep is checked word by word for lane data and address, and the sweep runs on past the memory's capacity so that discarded writes are seen.

Swap deferral is exercised with three separate blockers: a held critical flag, a host that has not yet acknowledged, and a transfer timed to straddle the spill wrap. In each case the bench checks the exact cycle on which the swap lands and the word count it reports.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             wordValid;
    logic             swapNow;
    logic [IDX_W-1:0] grantIdx;
  } rdoStrobe_t;
endpackage

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
  import rdo_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int PW         = 4,
  parameter int EVT_WORDS  = 32,
  parameter int SPILL_CLKS = 1250000,
  localparam int TW = $clog2(SPILL_CLKS),
  localparam int BW = (EVT_WORDS > 1) ? $clog2(EVT_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NCH*PW-1:0] chanPrio,
  input  logic [NCH-1:0]   chanCrit,
  input  logic             rdReady,
  output logic [NCH-1:0]   grant,
  output logic [TW-1:0]    spillTime,
  output rdoStrobe_t       str
);
  logic             busy;
  logic [BW-1:0]    beat;
  logic [IDX_W-1:0] curIdx;
  logic             pend;
  logic [IDX_W-1:0] winIdx;
  logic [PW-1:0]    winPrio;
  logic             swapNow, startXfer, spillEnd;

  // Strictly-greater scan from channel 0 upward keeps the lowest index on ties.
  always_comb begin
    winIdx  = '0;
    winPrio = '0;
    for (int i = 0; i < NCH; i++) begin
      if (chanPrio[i*PW +: PW] > winPrio) begin
        winPrio = chanPrio[i*PW +: PW];
        winIdx  = IDX_W'(i);
      end
    end
  end

  assign spillEnd  = (spillTime == TW'(SPILL_CLKS - 1));
  assign swapNow   = pend && !(|chanCrit) && !busy && !rdReady;
  assign startXfer = !busy && !swapNow && (winPrio != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spillTime <= '0;
      pend      <= 1'b0;
    end else begin
      spillTime <= spillEnd ? '0 : spillTime + 1'b1;
      if (spillEnd)     pend <= 1'b1;
      else if (swapNow) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      beat   <= '0;
      curIdx <= '0;
    end else if (startXfer) begin
      busy   <= 1'b1;
      beat   <= '0;
      curIdx <= winIdx;
    end else if (busy) begin
      if (beat == BW'(EVT_WORDS - 1)) busy <= 1'b0;
      beat <= beat + 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : gGrant
    assign grant[g] = busy && (curIdx == IDX_W'(g));
  end

  assign str.wordValid = busy;
  assign str.swapNow   = swapNow;
  assign str.grantIdx  = curIdx;

  // R1: single grant, held unchanged through a transfer
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(grant));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((|grant) && (|$past(grant))) |-> (grant == $past(grant)));
  // R4: timer steps by one and wraps at the spill length
  a_r4_step: assert property (@(posedge clk) disable iff (!rstN)
    (spillTime != TW'(SPILL_CLKS - 1)) |=> (spillTime == TW'($past(spillTime) + 1'b1)));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (spillTime == TW'(SPILL_CLKS - 1)) |=> (spillTime == '0));
endmodule

// File: rtl/rdo_dp.sv
module rdo_dp
  import rdo_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8192,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH*DW-1:0] chanData,
  input  logic              hostAck,
  input  rdoStrobe_t        str,
  output logic              memWrEn,
  output logic              memWrBank,
  output logic [AW-1:0]     memWrAddr,
  output logic [DW-1:0]     memWrData,
  output logic              rdReady,
  output logic              rdBank,
  output logic [AW:0]       rdCount,
  output logic              memFull
);
  logic [AW:0] wrCount;

  assign memFull   = (wrCount == (AW+1)'(DEPTH));
  assign memWrEn   = str.wordValid && !memFull;
  assign memWrAddr = wrCount[AW-1:0];
  assign rdBank    = ~memWrBank;

  always_comb begin
    memWrData = '0;
    for (int i = 0; i < NCH; i++) begin
      if (str.grantIdx == IDX_W'(i)) memWrData = chanData[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCount   <= '0;
      memWrBank <= 1'b0;
      rdReady   <= 1'b0;
      rdCount   <= '0;
    end else if (str.swapNow) begin
      memWrBank <= ~memWrBank;
      rdCount   <= wrCount;
      rdReady   <= 1'b1;
      wrCount   <= '0;
    end else begin
      if (memWrEn) wrCount <= wrCount + 1'b1;
      if (hostAck) rdReady <= 1'b0;
    end
  end

  // R5: the memories never swap in the middle of a transfer
  a_r5_swap_idle: assert property (@(posedge clk) disable iff (!rstN)
    (memWrBank != $past(memWrBank)) |-> !$past(str.wordValid));
  // R6: no swap while the host still holds the ready memory
  a_r6_no_swap_reading: assert property (@(posedge clk) disable iff (!rstN)
    (memWrBank != $past(memWrBank)) |-> !$past(rdReady));
  // R7: every swap raises ready
  a_r7_ready_on_swap: assert property (@(posedge clk) disable iff (!rstN)
    (memWrBank != $past(memWrBank)) |-> rdReady);
  // R8: a full memory takes no writes
  a_r8_full_no_write: assert property (@(posedge clk) disable iff (!rstN)
    memFull |-> !memWrEn);
endmodule

// File: rtl/rdo_arbiter.sv
module rdo_arbiter
  import rdo_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int PW         = 4,
  parameter int DW         = 32,
  parameter int DEPTH      = 8192,
  parameter int EVT_WORDS  = 32,
  parameter int SPILL_CLKS = 1250000,
  localparam int AW = $clog2(DEPTH),
  localparam int TW = $clog2(SPILL_CLKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH*PW-1:0] chanPrio,
  input  logic [NCH-1:0]    chanCrit,
  input  logic [NCH*DW-1:0] chanData,
  input  logic              hostAck,
  output logic [NCH-1:0]    grant,
  output logic              memWrEn,
  output logic              memWrBank,
  output logic [AW-1:0]     memWrAddr,
  output logic [DW-1:0]     memWrData,
  output logic [TW-1:0]     spillTime,
  output logic              rdReady,
  output logic              rdBank,
  output logic [AW:0]       rdCount,
  output logic              memFull
);
  rdoStrobe_t str;

  rdo_ctrl #(
    .NCH(NCH), .PW(PW), .EVT_WORDS(EVT_WORDS), .SPILL_CLKS(SPILL_CLKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .chanPrio(chanPrio), .chanCrit(chanCrit),
    .rdReady(rdReady), .grant(grant), .spillTime(spillTime), .str(str)
  );

  rdo_dp #(
    .NCH(NCH), .DW(DW), .DEPTH(DEPTH)
  ) uDp (
    .clk(clk), .rstN(rstN), .chanData(chanData), .hostAck(hostAck), .str(str),
    .memWrEn(memWrEn), .memWrBank(memWrBank), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .rdReady(rdReady), .rdBank(rdBank),
    .rdCount(rdCount), .memFull(memFull)
  );
endmodule

// File: tb/sim_rdo_arbiter.sv
`timescale 1ns/1ps
module sim_rdo_arbiter;
  localparam int NCH = 4, PW = 4, DW = 32, DEPTH = 16, EVT = 4, SPILL = 200;
  localparam int AW = $clog2(DEPTH), TW = $clog2(SPILL);

  logic clk = 1'b0, rstN = 1'b0, hostAck = 1'b0;
  logic [NCH*PW-1:0] chanPrio = '0;
  logic [NCH-1:0] chanCrit = '0;
  logic [NCH*DW-1:0] chanData;
  logic [NCH-1:0] grant;
  logic memWrEn, memWrBank, rdReady, rdBank, memFull;
  logic [AW-1:0] memWrAddr;
  logic [DW-1:0] memWrData;
  logic [TW-1:0] spillTime;
  logic [AW:0] rdCount;
  int nChecks = 0, nErr = 0, cyc = 0, wc = 0;

  always #5 clk = ~clk;

  for (genvar g = 0; g < NCH; g++) begin : gLane
    assign chanData[g*DW +: DW] = 32'hA5A5_0000 | (32'h111 * (g + 1));
  end

  rdo_arbiter #(.NCH(NCH), .PW(PW), .DW(DW), .DEPTH(DEPTH), .EVT_WORDS(EVT), .SPILL_CLKS(SPILL)) u0 (
    .clk(clk), .rstN(rstN), .chanPrio(chanPrio), .chanCrit(chanCrit), .chanData(chanData),
    .hostAck(hostAck), .grant(grant), .memWrEn(memWrEn), .memWrBank(memWrBank),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .spillTime(spillTime), .rdReady(rdReady),
    .rdBank(rdBank), .rdCount(rdCount), .memFull(memFull));

  always @(posedge clk) cyc <= rstN ? cyc + 1 : 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  endtask

  task automatic waitPhase(input int ph);
    while ((cyc % SPILL) != ph) @(negedge clk);
  endtask

  function automatic int lane(input int i);
    return 32'hA5A5_0000 | (32'h111 * (i + 1));
  endfunction

  initial begin
    #(200000 * 10);
    nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int win, best;
    logic [NCH-1:0] expG;
    chanCrit = 4'b0001;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(grant == '0 && !memWrEn, "R9 grant/write", {grant, memWrEn}, 0);
    chk(!rdReady && !memWrBank && !memFull, "R9 status", {rdReady, memWrBank, memFull}, 0);
    chk(spillTime == TW'(cyc % SPILL), "R4 timer after reset", spillTime, cyc % SPILL);

    // R2/R3 exhaustive priority sweep; crit held so swaps stay pending (R5 capture)
    for (int p = 0; p < 256; p++) begin
      best = 0; win = -1;
      for (int i = 0; i < NCH; i++) begin
        chanPrio[i*PW +: PW] = PW'((p >> (2*i)) & 3);
        if (((p >> (2*i)) & 3) > best) begin best = (p >> (2*i)) & 3; win = i; end
      end
      expG = (win < 0) ? '0 : NCH'(1 << win);
      @(negedge clk);
      chk(grant == expG, "R2 R3 winner", grant, expG);
      chanPrio = '0;
      if (win >= 0) begin
        for (int b = 0; b < EVT; b++) begin
          if (b > 0) @(negedge clk);
          chk(grant == expG, "R1 grant held", grant, expG);
          chk(memWrEn == (wc < DEPTH), "R8 write enable", memWrEn, wc < DEPTH);
          if (wc < DEPTH) begin
            chk(memWrAddr == AW'(wc) && memWrData == lane(win), "R1 addr/data",
                {memWrAddr, memWrData}, {AW'(wc), lane(win)});
            wc++;
          end
        end
        @(negedge clk);
        chk(grant == '0, "R1 transfer length", grant, 0);
      end
    end
    // R5: swap still waiting on crit, R8 full held
    chk(memFull == 1'b1, "R8 full sticky", memFull, 1);
    chk(!rdReady && !memWrBank, "R5 crit defers swap", {rdReady, memWrBank}, 0);
    chk(spillTime == TW'(cyc % SPILL), "R4 timer wraps", spillTime, cyc % SPILL);

    // R7: release crit, swap lands on the next edge
    chanCrit = '0;
    @(negedge clk);
    chk(rdReady && memWrBank && !rdBank, "R7 swap flags", {rdReady, memWrBank, rdBank}, 3'b110);
    chk(rdCount == (AW+1)'(DEPTH), "R7 count", rdCount, DEPTH);
    chk(!memFull && memWrAddr == '0, "R8 full cleared by swap", {memFull, memWrAddr}, 0);

    // R6: wrap occurs while ready is held; no swap until ack
    waitPhase(SPILL - 1);
    waitPhase(20);
    chk(rdReady && memWrBank, "R6 no swap while reading", {rdReady, memWrBank}, 2'b11);
    hostAck = 1'b1;
    @(negedge clk);
    hostAck = 1'b0;
    chk(!rdReady && memWrBank, "R6 ack clears ready", {rdReady, memWrBank}, 2'b01);
    @(negedge clk);
    chk(rdReady && !memWrBank && rdCount == '0, "R7 deferred swap", {rdReady, memWrBank, rdCount}, 2'b10 << (AW+1));
    hostAck = 1'b1;
    @(negedge clk);
    hostAck = 1'b0;
    @(negedge clk);
    chk(!rdReady && !memWrBank, "R6 ack with no pending swap", {rdReady, memWrBank}, 0);

    // R5: transfer straddling the spill wrap defers the swap
    waitPhase(SPILL - 2);
    chanPrio[2*PW +: PW] = 4'd5;
    @(negedge clk);
    chanPrio = '0;
    for (int b = 0; b < EVT; b++) begin
      if (b > 0) @(negedge clk);
      chk(grant == 4'b0100 && !rdReady, "R5 transfer blocks swap", {grant, rdReady}, 5'b01000);
    end
    @(negedge clk);
    chk(grant == '0 && !rdReady, "R5 swap one edge after transfer", {grant, rdReady}, 0);
    @(negedge clk);
    chk(rdReady && memWrBank && rdCount == (AW+1)'(EVT), "R7 count after straddle",
        {rdReady, memWrBank, rdCount}, {2'b11, (AW+1)'(EVT)});
    chk(spillTime == TW'(cyc % SPILL), "R4 timer at end", spillTime, cyc % SPILL);
    finishRun();
  end
endmodule